// File: doc/BRIEF.md
# Cyclic Converter Sequencer with Redundant-Digit Correction

This block is the digital side of a 12-bit cyclic (algorithmic) analog-to-digital converter that uses 1.5-bit stages. A one-cycle start strobe launches a conversion. The block then raises the enable for the master bias current sources, so the analog section draws power only while a conversion runs. It spends one clock period letting the bias settle while the input is sampled. Then it runs six amplification periods. In each of these periods the shared residue amplifier serves two phases, and each phase has its own comparator pair. So two redundant digits are captured per period, most significant first.

Each comparator pair gives a thermometer code that maps to a digit in {-1, 0, +1}. The block folds each digit into a running sum, weighted by its binary position. Successive digits overlap by one bit, so a comparator offset smaller than a quarter of the reference is absorbed by the later digits. At the end the sum is shifted to mid-scale and clamped to the output range. The 12-bit word appears together with a one-cycle done pulse, seven periods after the start edge, and the bias enable drops on the same edge. A start that arrives while a conversion is running is ignored.

Top module: `cadc_seq`

## Requirements
- R1: After reset, `busy_o`, `bias_en_o`, `sample_o`, `amp_o`, `done_o` and `code_err_o` are low, and `result_o` is 0.
- R2: A `start_i` seen high at a rising edge while idle raises `busy_o` and `bias_en_o` at that edge. `sample_o` is then high for exactly the first period after that edge, which is the settle period.
- R3: After the settle period, `amp_o` is high for six periods, and `sample_o` and `amp_o` are never high together. In each of those periods the comparator inputs are captured at the closing edge. Bits [1:0] carry the more significant digit of the pair and bits [3:2] the less significant one. Digit index i (0 to 11) is captured in period i/2.
- R4: A comparator pair code maps to a digit as follows: 2'b00 is -1, 2'b01 is 0 and 2'b11 is +1. The code 2'b10 is illegal and counts as 0.
- R5: The result is 2048 + sum over i of d_i * 2^(11-i). It is held on `result_o` from the done edge until the next done edge.
- R6: A sum below 0 gives 0, and a sum above 4095 gives 4095.
- R7: `done_o` is high for exactly one cycle, beginning 7 clock edges after the start edge. `busy_o` and `bias_en_o` fall on that same edge.
- R8: `start_i` is ignored while `busy_o` is high, including on the final edge. The running conversion completes unchanged and no new conversion follows.
- R9: `code_err_o` is high only together with `done_o`, and it is high if any illegal code was captured in that conversion. A later clean conversion reports it low.
- R10: Assume an ideal residue stage and comparator thresholds shifted by any common offset smaller than a quarter of the reference. The result then lies within 1 LSB of the ideal code of the input.
- R11: Comparator inputs have no effect while idle or in the settle period. This covers illegal codes, which raise no error flag there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-conversion strobe |
| cmp_i | input | 4 | Two comparator pairs, one per phase; [1:0] is the first phase |
| bias_en_o | output | 1 | Power-up enable for the master bias sources |
| busy_o | output | 1 | Conversion in progress |
| sample_o | output | 1 | Settle and sample period |
| amp_o | output | 1 | Residue amplification periods |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 12 | Corrected output word |
| code_err_o | output | 1 | Illegal comparator code seen, valid with done |

## Verification
The phase outputs change on the start edge: `busy_o`, `bias_en_o` and `sample_o` are checked half a period after it. `amp_o` is checked half a period after the following edge. Comparator codes are applied half a period before each of the six capture edges, so every pair is stable across the edge that takes it. The result, the error flag and the falling busy and bias lines are all due one half period after the seventh edge. The end of the done pulse is checked one period later. The expected words come from arithmetic on the applied digits, from single-digit sweeps, from pseudo-random digit patterns, and from an ideal residue model with shifted thresholds.

// File: rtl/cadc_pkg.sv
package cadc_pkg;
   // signed redundant digit: -1, 0, +1
   typedef logic signed [1:0] digit_t;

   // thermometer code of one comparator pair {upper, lower}
   typedef enum logic [1:0] {
      TH_BELOW = 2'b00,
      TH_MID   = 2'b01,
      TH_BAD   = 2'b10,
      TH_ABOVE = 2'b11
   } therm_e;

   localparam digit_t DG_NEG  = 2'sb11;
   localparam digit_t DG_ZERO = 2'sb00;
   localparam digit_t DG_POS  = 2'sb01;
endpackage

// File: rtl/cadc_digit_dec.sv
module cadc_digit_dec
   import cadc_pkg::*;
(
   input  logic [1:0] therm_i,
   output digit_t     dig_o,
   output logic       bad_o
);
   always_comb begin
      bad_o = 1'b0;
      unique case (therm_e'(therm_i))
         TH_BELOW: dig_o = DG_NEG;
         TH_MID:   dig_o = DG_ZERO;
         TH_ABOVE: dig_o = DG_POS;
         default: begin
            dig_o = DG_ZERO;
            bad_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/cadc_seq_ctrl.sv
module cadc_seq_ctrl #(
   parameter int SETTLE_CLKS = 1,
   parameter int NSTEP       = 6,
   localparam int TOTAL      = SETTLE_CLKS + NSTEP,
   localparam int CW         = $clog2(TOTAL + 1),
   localparam int PW         = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   output logic          busy_o,
   output logic          launch_o,
   output logic          sample_o,
   output logic          amp_o,
   output logic          last_o,
   output logic [PW-1:0] pair_idx_o
);
   logic [CW-1:0] ctr_q;
   logic          busy_q;

   assign launch_o = start_i && !busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         ctr_q  <= '0;
      end else if (launch_o) begin
         busy_q <= 1'b1;
         ctr_q  <= '0;
      end else if (busy_q) begin
         if (ctr_q == CW'(TOTAL - 1)) begin
            busy_q <= 1'b0;
            ctr_q  <= '0;
         end else begin
            ctr_q <= ctr_q + 1'b1;
         end
      end
   end

   assign busy_o     = busy_q;
   assign sample_o   = busy_q && (ctr_q <  CW'(SETTLE_CLKS));
   assign amp_o      = busy_q && (ctr_q >= CW'(SETTLE_CLKS));
   assign last_o     = busy_q && (ctr_q == CW'(TOTAL - 1));
   assign pair_idx_o = PW'(ctr_q - CW'(SETTLE_CLKS));
endmodule

// File: rtl/cadc_accum.sv
module cadc_accum
   import cadc_pkg::*;
#(
   parameter int RES_BITS    = 12,
   parameter int DIG_PER_CLK = 2,
   parameter int NSTEP       = 6,
   localparam int AW         = RES_BITS + 2,
   localparam int PW         = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 clear_i,
   input  logic                 capture_i,
   input  logic [PW-1:0]        pair_idx_i,
   input  digit_t               digits_i [DIG_PER_CLK],
   output logic signed [AW-1:0] acc_next_o
);
   logic signed [AW-1:0] acc_q;
   logic signed [AW-1:0] step_sum;
   logic signed [AW-1:0] ext;
   int                   idx;
   int                   sh;

   // weight of digit k is 2^(RES_BITS-1-k), k counted from the first capture
   always_comb begin
      step_sum = '0;
      ext      = '0;
      idx      = 0;
      sh       = 0;
      for (int j = 0; j < DIG_PER_CLK; j++) begin
         idx = int'(pair_idx_i) * DIG_PER_CLK + j;
         sh  = RES_BITS - 1 - idx;
         if (sh < 0) sh = 0;
         ext      = AW'(digits_i[j]);
         step_sum = step_sum + (ext <<< sh);
      end
      acc_next_o = acc_q + step_sum;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        acc_q <= '0;
      else if (clear_i)   acc_q <= '0;
      else if (capture_i) acc_q <= acc_next_o;
   end
endmodule

// File: rtl/cadc_clamp.sv
module cadc_clamp #(
   parameter int RES_BITS = 12,
   parameter bit SATURATE = 1'b1,
   localparam int AW      = RES_BITS + 2
) (
   input  logic signed [AW-1:0]   raw_i,
   output logic [RES_BITS-1:0]    code_o
);
   localparam logic signed [AW:0] MID  = (AW+1)'(1 << (RES_BITS - 1));
   localparam logic signed [AW:0] MAXV = (AW+1)'((1 << RES_BITS) - 1);

   logic signed [AW:0] biased;
   assign biased = {raw_i[AW-1], raw_i} + MID;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (biased < 0)          code_o = '0;
            else if (biased > MAXV)  code_o = '1;
            else                     code_o = biased[RES_BITS-1:0];
         end
      end else begin : g_wrap
         assign code_o = biased[RES_BITS-1:0];
      end
   endgenerate
endmodule

// File: rtl/cadc_seq.sv
module cadc_seq
   import cadc_pkg::*;
#(
   parameter int RES_BITS    = 12,
   parameter int DIG_PER_CLK = 2,
   parameter int SETTLE_CLKS = 1,
   parameter bit SATURATE    = 1'b1,
   localparam int NSTEP      = RES_BITS / DIG_PER_CLK,
   localparam int AW         = RES_BITS + 2,
   localparam int PW         = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     start_i,
   input  logic [2*DIG_PER_CLK-1:0] cmp_i,
   output logic                     bias_en_o,
   output logic                     busy_o,
   output logic                     sample_o,
   output logic                     amp_o,
   output logic                     done_o,
   output logic [RES_BITS-1:0]      result_o,
   output logic                     code_err_o
);
   generate
      if (RES_BITS < 2)
         $error("cadc_seq: RES_BITS must be at least 2");
      if (DIG_PER_CLK < 1 || DIG_PER_CLK > 4)
         $error("cadc_seq: DIG_PER_CLK must lie in 1..4");
      if (RES_BITS % DIG_PER_CLK != 0)
         $error("cadc_seq: RES_BITS must be a multiple of DIG_PER_CLK");
      if (SETTLE_CLKS < 1)
         $error("cadc_seq: SETTLE_CLKS must be at least 1");
   endgenerate

   logic                 launch, last;
   logic [PW-1:0]        pair_idx;
   digit_t               dig [DIG_PER_CLK];
   logic [DIG_PER_CLK-1:0] bad;
   logic signed [AW-1:0] acc_next;
   logic [RES_BITS-1:0]  code;
   logic                 err_acc_q, done_q, err_q;
   logic [RES_BITS-1:0]  result_q;

   cadc_seq_ctrl #(.SETTLE_CLKS(SETTLE_CLKS), .NSTEP(NSTEP)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .busy_o     (busy_o),
      .launch_o   (launch),
      .sample_o   (sample_o),
      .amp_o      (amp_o),
      .last_o     (last),
      .pair_idx_o (pair_idx)
   );

   for (genvar g = 0; g < DIG_PER_CLK; g++) begin : g_dec
      cadc_digit_dec u_dec (
         .therm_i (cmp_i[2*g +: 2]),
         .dig_o   (dig[g]),
         .bad_o   (bad[g])
      );
   end

   cadc_accum #(.RES_BITS(RES_BITS), .DIG_PER_CLK(DIG_PER_CLK), .NSTEP(NSTEP)) u_acc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (launch),
      .capture_i  (amp_o),
      .pair_idx_i (pair_idx),
      .digits_i   (dig),
      .acc_next_o (acc_next)
   );

   cadc_clamp #(.RES_BITS(RES_BITS), .SATURATE(SATURATE)) u_clamp (
      .raw_i  (acc_next),
      .code_o (code)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_acc_q <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         result_q  <= '0;
      end else begin
         done_q <= last;
         err_q  <= last && (err_acc_q || (|bad));
         if (launch)     err_acc_q <= 1'b0;
         else if (amp_o) err_acc_q <= err_acc_q || (|bad);
         if (last)       result_q  <= code;
      end
   end

   assign bias_en_o  = busy_o;
   assign done_o     = done_q;
   assign result_o   = result_q;
   assign code_err_o = err_q;
endmodule

module cadc_seq_chk #(
   parameter int RES_BITS = 12,
   parameter int TOTAL    = 7
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                start_i,
   input logic                bias_en_o,
   input logic                busy_o,
   input logic                sample_o,
   input logic                amp_o,
   input logic                done_o,
   input logic [RES_BITS-1:0] result_o,
   input logic                code_err_o
);
   logic [15:0] run_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  run_cnt <= '0;
      else if (start_i && !busy_o)  run_cnt <= '0;
      else if (busy_o)              run_cnt <= run_cnt + 1'b1;
   end

   AST_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i && !busy_o |=> busy_o && bias_en_o && sample_o);  // R2
   AST_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(start_i));  // R2
   AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sample_o && amp_o));  // R3
   AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !sample_o && !amp_o);  // R3
   AST_SETTLE_TO_AMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sample_o) && busy_o |-> amp_o);  // R3
   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);  // R7
   AST_DONE_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> run_cnt == 16'(TOTAL) && !busy_o && !bias_en_o);  // R7
   AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o));  // R5
   AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_err_o |-> done_o);  // R9
endmodule

bind cadc_seq cadc_seq_chk #(
   .RES_BITS (RES_BITS),
   .TOTAL    (SETTLE_CLKS + RES_BITS / DIG_PER_CLK)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .start_i    (start_i),
   .bias_en_o  (bias_en_o),
   .busy_o     (busy_o),
   .sample_o   (sample_o),
   .amp_o      (amp_o),
   .done_o     (done_o),
   .result_o   (result_o),
   .code_err_o (code_err_o)
);

// File: tb/sim_cadc_seq.sv
module sim_cadc_seq;
   localparam int NB   = 12;
   localparam int NDG  = 12;
   localparam int S    = 65536;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  cmp_i = 4'b1010;
   logic        bias_en_o, busy_o, sample_o, amp_o, done_o, code_err_o;
   logic [11:0] result_o;

   int n_chk = 0;
   int n_bad = 0;
   int dig_v [NDG];
   bit bad_v [NDG];
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk_i = ~clk_i;

   cadc_seq u0 (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmp_i(cmp_i),
      .bias_en_o(bias_en_o), .busy_o(busy_o), .sample_o(sample_o),
      .amp_o(amp_o), .done_o(done_o), .result_o(result_o),
      .code_err_o(code_err_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [1:0] enc(input int d, input bit b);
      if (b) return 2'b10;
      if (d > 0) return 2'b11;
      if (d < 0) return 2'b00;
      return 2'b01;
   endfunction

   function automatic int exp_code();
      int raw = 0;
      for (int i = 0; i < NDG; i++)
         if (!bad_v[i]) raw += dig_v[i] * (1 << (NDG - 1 - i));
      raw += 2048;
      if (raw < 0) raw = 0;
      if (raw > 4095) raw = 4095;
      return raw;
   endfunction

   function automatic bit exp_err();
      for (int i = 0; i < NDG; i++) if (bad_v[i]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic void clear_vec();
      for (int i = 0; i < NDG; i++) begin
         dig_v[i] = 0;
         bad_v[i] = 1'b0;
      end
   endfunction

   // ideal 1.5-bit residue stage with both thresholds shifted by off
   function automatic void model(input int x, input int off);
      int r = x;
      for (int i = 0; i < NDG; i++) begin
         int d;
         if (r > S/4 + off)       d = 1;
         else if (r < -S/4 + off) d = -1;
         else                     d = 0;
         dig_v[i] = d;
         bad_v[i] = 1'b0;
         r = 2*r - d*S;
      end
   endfunction

   // full conversion; poke_busy pulses start inside the run and on the last edge
   task automatic conv(input bit poke_busy, output int res);
      int ec;
      bit ee;
      ec = exp_code();
      ee = exp_err();
      @(negedge clk_i);
      start_i = 1'b1;
      cmp_i   = 4'b1010;
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      check(busy_o && bias_en_o, "R2 busy/bias at start", int'(busy_o & bias_en_o), 1);
      check(sample_o && !amp_o, "R2 settle phase", int'(sample_o), 1);
      cmp_i = 4'b1010;  // illegal codes during settle must be ignored (R11)
      for (int k = 0; k < NDG/2; k++) begin
         @(negedge clk_i);
         if (k == 0) check(amp_o && !sample_o, "R3 amp phase", int'(amp_o), 1);
         cmp_i   = {enc(dig_v[2*k+1], bad_v[2*k+1]), enc(dig_v[2*k], bad_v[2*k])};
         start_i = poke_busy && (k == 2 || k == NDG/2 - 1);
      end
      @(negedge clk_i);
      start_i = 1'b0;
      cmp_i   = 4'b1010;
      res     = int'(result_o);
      check(done_o, "R7 done after 7 edges", int'(done_o), 1);
      check(!busy_o && !bias_en_o, "R7 bias off at done", int'(busy_o | bias_en_o), 0);
      check(int'(result_o) == ec, "R5 result", int'(result_o), ec);
      check(code_err_o == ee, "R9 error flag", int'(code_err_o), int'(ee));
      @(negedge clk_i);
      check(!done_o, "R7 done one cycle", int'(done_o), 0);
      if (poke_busy) check(!busy_o, "R8 start while busy ignored", int'(busy_o), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk_i);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int res;
      repeat (3) @(negedge clk_i);
      check(!busy_o && !bias_en_o && !sample_o && !amp_o, "R1 reset phases", int'(busy_o), 0);
      check(!done_o && !code_err_o && result_o == '0, "R1 reset outputs", int'(result_o), 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check(!busy_o && !done_o && result_o == '0, "R1 after release", int'(result_o), 0);

      // R11: comparator activity while idle does nothing
      for (int c = 0; c < 4; c++) begin
         cmp_i = 4'(c * 5);
         @(negedge clk_i);
      end
      check(!done_o && !busy_o && result_o == '0 && !code_err_o, "R11 idle inputs ignored",
            int'(result_o), 0);

      // R5/R6: one nonzero digit at a time, both signs
      for (int i = 0; i < NDG; i++) begin
         for (int s = 0; s < 2; s++) begin
            clear_vec();
            dig_v[i] = (s == 0) ? 1 : -1;
            conv(1'b0, res);
         end
      end
      // R6: full-scale patterns
      clear_vec();
      for (int i = 0; i < NDG; i++) dig_v[i] = 1;
      conv(1'b0, res);
      check(res == 4095, "R6 clamp high", res, 4095);
      for (int i = 0; i < NDG; i++) dig_v[i] = -1;
      conv(1'b0, res);
      check(res == 0, "R6 clamp low", res, 0);
      clear_vec();
      conv(1'b0, res);
      check(res == 2048, "R5 mid-scale", res, 2048);

      // R4/R9: illegal code counts as zero and flags error, then clears
      clear_vec();
      dig_v[0] = 1; dig_v[3] = 1; bad_v[3] = 1'b1; dig_v[7] = -1;
      conv(1'b0, res);
      check(res == 2048 + 2048 - 16, "R4 illegal digit as zero", res, 4080);
      bad_v[3] = 1'b0;
      conv(1'b0, res);
      check(res == 4095, "R9 clean run after error", res, 4095);

      // pseudo-random digit patterns, some with busy starts (R8)
      for (int t = 0; t < 40; t++) begin
         for (int i = 0; i < NDG; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dig_v[i] = int'(lfsr[1:0] % 3) - 1;
            bad_v[i] = (t % 7 == 3) && (i == t % NDG);
         end
         conv(t % 3 == 0, res);
      end

      // R10: ideal residue model with offset thresholds
      for (int o = 0; o < 3; o++) begin
         int off = (o == 0) ? 0 : ((o == 1) ? 5000 : -5000);
         for (int m = -2000; m <= 2000; m += 97) begin
            int ideal;
            model(16 * m, off);
            conv(1'b0, res);
            ideal = 2048 + m;
            check(res - ideal <= 1 && ideal - res <= 1, "R10 offset tolerance", res, ideal);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule